// File: doc/BRIEF.md
# Word-Addressed RAM Target on a Valid/Acknowledge Port

This block is a small synchronous memory slave that sits behind a split command/response port. An initiator presents one command cell at a time: an address, write data, byte-lane enables, a command code, a packet length in bytes, an end-of-packet flag and three tag fields (source, thread and packet identifiers). The memory either stores the write data into the addressed 32-bit word or reads that word. It then returns exactly one response cell carrying the read data, an error flag, an end-of-packet flag and the three echoed tags.

The controller has three states: idle, middle-of-packet response pending, and last-of-packet response pending. Command acceptance and response delivery never overlap. `cmd_ack` is high only while idle, and `rsp_val` is high only while a response waits. Both handshakes follow the valid/ready rule. A command transfers on a rising edge where `cmd_val` and `cmd_ack` are both high. A response transfers on a rising edge where `rsp_val` and `rsp_ack` are both high. While `rsp_ack` is low the response is back-pressured, and every response field stays frozen. All handshake outputs come from registered state only.

Top module: `vci_ram_target`

## Requirements
- R1: While `rst_n` is low, the next rising edge places the block in idle, with `cmd_ack`=1 and `rsp_val`=0.
- R2: In idle, `cmd_ack`=1 and `rsp_val`=0. While a response is pending, `cmd_ack`=0 and `rsp_val`=1.
- R3: A command accepted with `cmd_eop`=1 yields `rsp_val`=1 and `rsp_eop`=1 from the next cycle. A command accepted with `cmd_eop`=0 yields `rsp_eop`=0.
- R4: A pending response and its flags stay unchanged while `rsp_ack`=0. On the edge where `rsp_ack`=1, the block returns to idle.
- R5: Command code 2'b10 is a write. It updates the word at index `cmd_addr`>>2, and each lane i (bits 8i+7..8i) changes only when `cmd_be[i]`=1. A write response returns the word's contents from before the write.
- R6: Any other command code is a read, and `rsp_rdata` returns the word at `cmd_addr`>>2. The value is captured at acceptance and held stable while `rsp_val`=1.
- R7: An address at or above 4*DEPTH bytes gives `rsp_err`=1 and `rsp_rdata`=0, and it modifies no storage. In-range accesses give `rsp_err`=0.
- R8: `rsp_srcid`, `rsp_trdid` and `rsp_pktid` equal the values presented with the accepted command.
- R9: A `cmd_val` asserted while a response is pending is not taken, and a write presented then leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_val | input | 1 | Command cell valid |
| cmd_ack | output | 1 | Command cell accepted (ready) |
| cmd_addr | input | 32 | Byte address |
| cmd_wdata | input | 32 | Write data |
| cmd_be | input | 4 | Byte-lane enables |
| cmd_code | input | 2 | Command code, 2'b10 = write, others read |
| cmd_plen | input | 8 | Packet length in bytes, nonzero |
| cmd_eop | input | 1 | Last cell of packet |
| cmd_srcid | input | 8 | Source identifier |
| cmd_trdid | input | 1 | Thread identifier |
| cmd_pktid | input | 1 | Packet identifier |
| rsp_val | output | 1 | Response cell valid |
| rsp_ack | input | 1 | Response cell taken (ready) |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access error |
| rsp_eop | output | 1 | Last response of packet |
| rsp_srcid | output | 8 | Echoed source identifier |
| rsp_trdid | output | 1 | Echoed thread identifier |
| rsp_pktid | output | 1 | Echoed packet identifier |

## Verification
The in-line properties check the handshake on every cycle: the reset landing, the end-of-packet flag that follows from an accepted command, freezing of the whole response under back-pressure, the return to idle after `rsp_ack`, the error flag for out-of-range addresses, and tag echo. Only the bench scenarios can show what the memory holds. That covers byte-lane merging on writes, old-data return on write responses, the absence of writes for out-of-range addresses, and commands offered while a response is pending. A reference memory model follows each access, and later reads compare against it.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MID  = 2'd1,
    ST_LAST = 2'd2
  } vram_state_e;

  localparam logic [1:0] CODE_WRITE = 2'b10;
endpackage

// File: rtl/vram_ctrl.sv
module vram_ctrl
  import vram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_val,
  input  logic cmd_last,
  input  logic rsp_ack,
  output logic cmd_ack,
  output logic rsp_val,
  output logic rsp_last,
  output logic accept
);
  vram_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (cmd_val) state_d = cmd_last ? ST_LAST : ST_MID;
      ST_MID, ST_LAST: if (rsp_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Moore outputs: decoded from the state register only
  assign cmd_ack  = (state_q == ST_IDLE);
  assign rsp_val  = (state_q == ST_MID) || (state_q == ST_LAST);
  assign rsp_last = (state_q == ST_LAST);
  assign accept   = cmd_val && cmd_ack;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> cmd_ack && !rsp_val);

  assert_accept_eop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && cmd_ack |=> rsp_val && (rsp_last == $past(cmd_last)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_val && !rsp_ack |=> rsp_val && $stable(rsp_last) && !cmd_ack);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_val && rsp_ack |=> cmd_ack && !rsp_val);
endmodule

// File: rtl/vram_store.sv
module vram_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  // One independent byte-wide array per lane
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) lane_mem[wr_idx] <= wr_data[g*8 +: 8];
    end

    assign rd_data[g*8 +: 8] = lane_mem[rd_idx];
  end
endmodule

// File: rtl/vram_rsp.sv
module vram_rsp #(
  parameter int DATA_W  = 32,
  parameter int SRCID_W = 8,
  parameter int TRDID_W = 1,
  parameter int PKTID_W = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DATA_W-1:0]  rdata_d,
  input  logic               err_d,
  input  logic [SRCID_W-1:0] srcid_d,
  input  logic [TRDID_W-1:0] trdid_d,
  input  logic [PKTID_W-1:0] pktid_d,
  output logic [DATA_W-1:0]  rdata_q,
  output logic               err_q,
  output logic [SRCID_W-1:0] srcid_q,
  output logic [TRDID_W-1:0] trdid_q,
  output logic [PKTID_W-1:0] pktid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      srcid_q <= '0;
      trdid_q <= '0;
      pktid_q <= '0;
    end else if (load) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
      srcid_q <= srcid_d;
      trdid_q <= trdid_d;
      pktid_q <= pktid_d;
    end
  end
endmodule

// File: rtl/vci_ram_target.sv
module vci_ram_target
  import vram_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 64,
  parameter int PLEN_W  = 8,
  parameter int SRCID_W = 8,
  parameter int TRDID_W = 1,
  parameter int PKTID_W = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_val,
  output logic               cmd_ack,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic [DATA_W/8-1:0] cmd_be,
  input  logic [1:0]         cmd_code,
  input  logic [PLEN_W-1:0]  cmd_plen,
  input  logic               cmd_eop,
  input  logic [SRCID_W-1:0] cmd_srcid,
  input  logic [TRDID_W-1:0] cmd_trdid,
  input  logic [PKTID_W-1:0] cmd_pktid,
  output logic               rsp_val,
  input  logic               rsp_ack,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               rsp_eop,
  output logic [SRCID_W-1:0] rsp_srcid,
  output logic [TRDID_W-1:0] rsp_trdid,
  output logic [PKTID_W-1:0] rsp_pktid
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFF_W = $clog2(BE_W);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(DEPTH * BE_W);

  logic              accept;
  logic              in_range;
  logic              wr_en;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] store_rd;
  logic [DATA_W-1:0] rd_sel;

  assign in_range = (cmd_addr < SPAN);
  assign word_idx = cmd_addr[OFF_W +: IDX_W];
  assign wr_en    = accept && in_range && (cmd_code == CODE_WRITE);
  assign rd_sel   = in_range ? store_rd : '0;

  vram_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_val  (cmd_val),
    .cmd_last (cmd_eop),
    .rsp_ack  (rsp_ack),
    .cmd_ack  (cmd_ack),
    .rsp_val  (rsp_val),
    .rsp_last (rsp_eop),
    .accept   (accept)
  );

  vram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (word_idx),
    .wr_data (cmd_wdata),
    .wr_be   (cmd_be),
    .rd_idx  (word_idx),
    .rd_data (store_rd)
  );

  vram_rsp #(
    .DATA_W(DATA_W), .SRCID_W(SRCID_W), .TRDID_W(TRDID_W), .PKTID_W(PKTID_W)
  ) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .rdata_d (rd_sel),
    .err_d   (!in_range),
    .srcid_d (cmd_srcid),
    .trdid_d (cmd_trdid),
    .pktid_d (cmd_pktid),
    .rdata_q (rsp_rdata),
    .err_q   (rsp_err),
    .srcid_q (rsp_srcid),
    .trdid_q (rsp_trdid),
    .pktid_q (rsp_pktid)
  );

  // Packet length is carried for the initiator's framing; it must be nonzero
  assert_plen_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && cmd_ack |-> cmd_plen != '0);

  assert_err_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && cmd_ack |=> rsp_err == ($past(cmd_addr) >= SPAN));

  assert_tag_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && cmd_ack |=> rsp_srcid == $past(cmd_srcid)
      && rsp_trdid == $past(cmd_trdid) && rsp_pktid == $past(cmd_pktid));

  assert_rsp_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_val && !rsp_ack |=> $stable(rsp_rdata) && $stable(rsp_err)
      && $stable(rsp_srcid) && $stable(rsp_trdid) && $stable(rsp_pktid));
endmodule

// File: tb/vci_ram_target_tb.sv
`timescale 1ns/1ps
module vci_ram_target_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_val = 1'b0, cmd_ack;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic [3:0]  cmd_be = '0;
  logic [1:0]  cmd_code = '0;
  logic [7:0]  cmd_plen = 8'd4;
  logic        cmd_eop = 1'b0;
  logic [7:0]  cmd_srcid = '0;
  logic        cmd_trdid = 1'b0, cmd_pktid = 1'b0;
  logic        rsp_val, rsp_ack = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err, rsp_eop;
  logic [7:0]  rsp_srcid;
  logic        rsp_trdid, rsp_pktid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model [DEPTH];

  always #4 clk = ~clk;

  vci_ram_target #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_val(cmd_val), .cmd_ack(cmd_ack), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_be(cmd_be), .cmd_code(cmd_code),
    .cmd_plen(cmd_plen), .cmd_eop(cmd_eop), .cmd_srcid(cmd_srcid),
    .cmd_trdid(cmd_trdid), .cmd_pktid(cmd_pktid),
    .rsp_val(rsp_val), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_eop(rsp_eop), .rsp_srcid(rsp_srcid),
    .rsp_trdid(rsp_trdid), .rsp_pktid(rsp_pktid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old_w,
      input logic [31:0] new_w, input logic [3:0] be);
    logic [31:0] r = old_w;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  // One full command/response exchange; hold = cycles of back-pressure
  task automatic xfer(input logic [31:0] addr, input logic [31:0] wd,
      input logic [3:0] be, input logic [1:0] code, input logic eop,
      input logic [7:0] sid, input logic tid, input logic pid,
      input int hold, input bit junk);
    bit oob = (addr >= 32'(DEPTH * 4));
    logic [31:0] exp_rd = oob ? 32'h0 : model[addr[7:2]];
    @(negedge clk);
    chk(cmd_ack === 1'b1 && rsp_val === 1'b0, "R2 idle handshake",
        {30'd0, cmd_ack, rsp_val}, 32'h2);
    cmd_val = 1'b1; cmd_addr = addr; cmd_wdata = wd; cmd_be = be;
    cmd_code = code; cmd_eop = eop; cmd_srcid = sid; cmd_trdid = tid;
    cmd_pktid = pid; cmd_plen = 8'd4;
    @(negedge clk);
    cmd_val = 1'b0;
    chk(rsp_val === 1'b1 && cmd_ack === 1'b0, "R2 pending handshake",
        {30'd0, cmd_ack, rsp_val}, 32'h1);
    chk(rsp_eop === eop, "R3 end-of-packet flag", {31'd0, rsp_eop}, {31'd0, eop});
    chk(rsp_err === oob, "R7 error flag", {31'd0, rsp_err}, {31'd0, oob});
    chk(rsp_rdata === exp_rd, code == 2'b10 ? "R5 old data on write" : "R6 read data",
        rsp_rdata, exp_rd);
    chk(rsp_srcid === sid && rsp_trdid === tid && rsp_pktid === pid, "R8 tag echo",
        {22'd0, rsp_srcid, rsp_trdid, rsp_pktid}, {22'd0, sid, tid, pid});
    for (int h = 0; h < hold; h++) begin
      if (junk) begin
        // R9: offered while busy, must not be taken
        cmd_val = 1'b1; cmd_code = 2'b10; cmd_be = 4'hF;
        cmd_wdata = ~wd; cmd_addr = addr; cmd_eop = ~eop;
      end
      @(negedge clk);
      chk(rsp_val === 1'b1 && rsp_eop === eop && rsp_rdata === exp_rd
          && rsp_err === oob, "R4 held under back-pressure", rsp_rdata, exp_rd);
    end
    cmd_val = 1'b0;
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(cmd_ack === 1'b1 && rsp_val === 1'b0, "R4 return to idle",
        {30'd0, cmd_ack, rsp_val}, 32'h2);
    if (!oob && code == 2'b10) model[addr[7:2]] = merge(model[addr[7:2]], wd, be);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cmd_ack === 1'b1 && rsp_val === 1'b0, "R1 reset state",
        {30'd0, cmd_ack, rsp_val}, 32'h2);
    rst_n = 1'b1;

    // Fill memory with known contents (R5 full-lane writes)
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 32'h0;
      xfer(32'(i * 4), 32'hA5000000 + 32'(i * 32'h01010101), 4'hF, 2'b10, 1'b1,
           8'(i), 1'b0, 1'b1, 0, 1'b0);
    end
    for (int i = 0; i < DEPTH; i++)
      xfer(32'(i * 4), 32'h0, 4'h0, 2'b01, 1'b1, 8'hFF, 1'b1, 1'b0, 0, 1'b0);

    // R5 partial lanes, checked by read-back
    xfer(32'h10, 32'h11223344, 4'b0101, 2'b10, 1'b0, 8'h12, 1'b1, 1'b1, 1, 1'b0);
    xfer(32'h10, 32'h0, 4'h0, 2'b01, 1'b1, 8'h13, 1'b0, 1'b0, 0, 1'b0);
    // R7 out of range write then in-range neighbours unchanged
    xfer(32'(DEPTH * 4), 32'hDEADBEEF, 4'hF, 2'b10, 1'b1, 8'h20, 1'b0, 1'b0, 2, 1'b0);
    xfer(32'hFFFFFFFC, 32'hDEADBEEF, 4'hF, 2'b10, 1'b0, 8'h21, 1'b1, 1'b0, 0, 1'b0);
    xfer(32'h0, 32'h0, 4'h0, 2'b00, 1'b1, 8'h22, 1'b0, 1'b1, 0, 1'b0);
    // R9 commands offered during a pending response are ignored
    xfer(32'h20, 32'hCAFEF00D, 4'hF, 2'b10, 1'b1, 8'h30, 1'b0, 1'b0, 0, 1'b0);
    xfer(32'h20, 32'h0, 4'h0, 2'b01, 1'b0, 8'h31, 1'b0, 1'b0, 4, 1'b1);
    xfer(32'h20, 32'h0, 4'h0, 2'b01, 1'b1, 8'h32, 1'b1, 1'b1, 0, 1'b0);

    // Constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = 32'($urandom_range(0, DEPTH * 4 + 31)) & 32'hFFFFFFFC;
      xfer(a, $urandom, 4'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), int'($urandom_range(0, 3)), 1'($urandom));
    end
    // Final sweep of all words against the model
    for (int i = 0; i < DEPTH; i++)
      xfer(32'(i * 4), 32'h0, 4'h0, 2'b11, 1'b1, 8'h5A, 1'b0, 1'b0, 0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule